// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block watches the command stream that a memory controller drives toward a four-bank synchronous DRAM and keeps a model of the bank state. It samples the four active-low command strobes, the bank select and the 12-bit address bus on every rising clock edge. For each bank it records whether a row is open and which row that is. A one-cycle error pulse is raised for any command that breaks the bank protocol: touching a closed bank, opening a bank that is already open, refreshing while any bank is open, or issuing a command before its programmed spacing has elapsed.

Two minimum spacings come from configuration inputs. One runs from opening a row to the first column access on that bank. The other runs from closing a bank to the next open of that bank. A column access can request that the bank close itself after the burst. The bank then goes idle once the burst length plus a programmed close delay has passed. That request is ignored while full-page bursts are configured.

The tracker only observes, so it applies no back-pressure. It accepts one command on every clock, and it has no valid/ready handshake. All outputs are registered. Bank state and the error pulse reflect a command from the clock edge that samples it.

Top module: `sdram_row_tracker`

## Requirements
- R1: A synchronous active-high reset clears every bit of `bank_open` and clears `err_pulse`. After reset, an open command to any bank is accepted at once.
- R2: A command is decoded only while `cmd_chip_n` is low. The strobes (`cmd_row_n`, `cmd_col_n`, `cmd_wr_n`) decode as follows: 0,1,1 open; 1,0,1 read; 1,0,0 write; 0,1,0 close; 0,0,1 refresh. Every other pattern, and any cycle with `cmd_chip_n` high, changes no state and raises no error.
- R3: An open command to an idle bank whose close spacing has been met sets that bank's open flag. It also stores `addr_bus[11:0]` as that bank's row. Bank i maps to `bank_open[i]` and `open_row[12*i+11:12*i]`, and both update at the sampling edge.
- R4: An open command to a bank that is already open raises the error pulse and leaves the stored row unchanged.
- R5: A read or write to an idle bank raises the error pulse.
- R6: A read or write that comes fewer than `cfg_act_gap` cycles after the open command of that bank raises the error pulse. Exactly `cfg_act_gap` cycles is legal.
- R7: A close command with `addr_bus[10]` low closes only the bank on `bank_sel`. With `addr_bus[10]` high it closes all four banks.
- R8: An open command that comes fewer than `cfg_pre_gap` cycles after that bank was closed raises the error pulse, and the bank stays idle. Exactly `cfg_pre_gap` cycles is legal.
- R9: A legal read or write with `addr_bus[10]` high closes its bank `cfg_burst_len + cfg_close_dly` cycles after the command edge. A read or write to that bank while the close is pending raises the error pulse.
- R10: While `cfg_full_page` is high, `addr_bus[10]` on a read or write has no effect, and the bank stays open.
- R11: A refresh while any bank is open raises the error pulse. A refresh with all banks idle is legal.
- R12: An illegal command changes no bank state. `err_pulse` is high for exactly the one cycle after the sampling edge of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_chip_n | input | 1 | Active-low command select |
| cmd_row_n | input | 1 | Active-low row strobe |
| cmd_col_n | input | 1 | Active-low column strobe |
| cmd_wr_n | input | 1 | Active-low write strobe |
| bank_sel | input | 2 | Bank addressed by the command |
| addr_bus | input | 12 | Row on open; bit 10 is the all-banks or self-close flag |
| cfg_act_gap | input | 4 | Minimum cycles from open to column access |
| cfg_pre_gap | input | 4 | Minimum cycles from close to open |
| cfg_burst_len | input | 4 | Burst length in cycles used for self-close |
| cfg_close_dly | input | 4 | Extra cycles after the burst before self-close |
| cfg_full_page | input | 1 | Full-page bursts; disables self-close |
| bank_open | output | 4 | Per-bank open flag |
| open_row | output | 48 | Per-bank stored row, 12 bits per bank |
| err_pulse | output | 1 | One-cycle flag for an illegal command |

## Verification
The bench builds the tracker with its default parameters: 12-bit rows, four-bit spacing counters and four-bit burst and delay fields. It drives the configuration pins with a spacing of 2 from open to access and 3 from close to open, a burst of 4 and a close delay of 2. With these values, both spacing boundaries (one cycle early and exactly on time) and the full six-cycle self-close window fall within a few cycles of stimulus. A second phase sets full-page mode to show that the self-close request is ignored.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_OPEN    = 3'd1,
    CMD_READ    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_CLOSE   = 3'd4,
    CMD_REFRESH = 3'd5
  } sbt_cmd_e;

  // Strobe decode; unsupported patterns fold into CMD_NONE.
  function automatic sbt_cmd_e sbt_decode(input logic chip_n, input logic row_n,
                                          input logic col_n, input logic wr_n);
    sbt_cmd_e c;
    c = CMD_NONE;
    if (!chip_n) begin
      case ({row_n, col_n, wr_n})
        3'b011:  c = CMD_OPEN;
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b010:  c = CMD_CLOSE;
        3'b001:  c = CMD_REFRESH;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int FLAG_BIT = 10
) (
  input  logic              chip_n,
  input  logic              row_n,
  input  logic              col_n,
  input  logic              wr_n,
  input  logic [BA_W-1:0]   bank_sel,
  input  logic [ADDR_W-1:0] addr,
  output sbt_cmd_e          cmd,
  output logic [BANKS-1:0]  bank_hit,
  output logic              flag_bit
);

  assign cmd      = sbt_decode(chip_n, row_n, col_n, wr_n);
  assign flag_bit = addr[FLAG_BIT];

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_hit
    assign bank_hit[gi] = (bank_sel == BA_W'(gi));
  end

endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot
  import sbt_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int GAP_W = 4,
  parameter int BL_W  = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sbt_cmd_e         cmd,
  input  logic             hit,
  input  logic             flag_bit,
  input  logic             full_page,
  input  logic [ROW_W-1:0] row_in,
  input  logic [GAP_W-1:0] act_gap,
  input  logic [GAP_W-1:0] pre_gap,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [DLY_W-1:0] close_dly,
  output logic             is_open,
  output logic [ROW_W-1:0] row,
  output logic             cmd_err
);

  localparam int CNT_W = ((BL_W > DLY_W) ? BL_W : DLY_W) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] since_q;
  logic             pend_q;
  logic [CNT_W-1:0] pend_cnt_q;
  logic [CNT_W-1:0] pend_load;

  logic do_open, do_rw, do_close, expire;
  logic err_open, err_rw;

  assign do_open  = (cmd == CMD_OPEN) && hit;
  assign do_rw    = ((cmd == CMD_READ) || (cmd == CMD_WRITE)) && hit;
  assign do_close = (cmd == CMD_CLOSE) && (hit || flag_bit);
  assign expire   = pend_q && (pend_cnt_q == CNT_W'(1));

  assign err_open = do_open && (is_open || (since_q < pre_gap));
  assign err_rw   = do_rw && (!is_open || pend_q || (since_q < act_gap));
  assign cmd_err  = err_open || err_rw;

  always_comb begin
    pend_load = CNT_W'(burst_len) + CNT_W'(close_dly);
    if (pend_load == '0) pend_load = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open    <= 1'b0;
      row        <= '0;
      since_q    <= GAP_MAX;
      pend_q     <= 1'b0;
      pend_cnt_q <= '0;
    end else begin
      if (do_open && !err_open) begin
        is_open <= 1'b1;
        row     <= row_in;
        since_q <= GAP_W'(1);
      end else if ((do_close && is_open) || expire) begin
        is_open <= 1'b0;
        pend_q  <= 1'b0;
        since_q <= GAP_W'(1);
      end else begin
        if (since_q != GAP_MAX) since_q <= since_q + GAP_W'(1);
        if (pend_q) pend_cnt_q <= pend_cnt_q - CNT_W'(1);
        if (do_rw && !err_rw && flag_bit && !full_page) begin
          pend_q     <= 1'b1;
          pend_cnt_q <= pend_load;
        end
      end
    end
  end

  // R3: an idle bank only opens through an open command to it
  a_r3_open_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    (!is_open && !do_open) |=> !is_open);

  // R7: a close naming this bank (or all banks) leaves it idle
  a_r7_close_idles: assert property (@(posedge clk) disable iff (rst)
    do_close |=> !is_open);

  // R12: stored row moves only on an open command to this bank
  a_r12_row_holds: assert property (@(posedge clk) disable iff (rst)
    !do_open |=> $stable(row));

  // R9: a pending self-close never outlives the open row
  a_r9_pend_only_open: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> is_open);

endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
  import sbt_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int GAP_W = 4,
  parameter int BL_W  = 4,
  parameter int DLY_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_chip_n,
  input  logic                   cmd_row_n,
  input  logic                   cmd_col_n,
  input  logic                   cmd_wr_n,
  input  logic [BA_W-1:0]        bank_sel,
  input  logic [ROW_W-1:0]       addr_bus,
  input  logic [GAP_W-1:0]       cfg_act_gap,
  input  logic [GAP_W-1:0]       cfg_pre_gap,
  input  logic [BL_W-1:0]        cfg_burst_len,
  input  logic [DLY_W-1:0]       cfg_close_dly,
  input  logic                   cfg_full_page,
  output logic [BANKS-1:0]       bank_open,
  output logic [BANKS*ROW_W-1:0] open_row,
  output logic                   err_pulse
);

  sbt_cmd_e         cmd;
  logic [BANKS-1:0] bank_hit;
  logic             flag_bit;
  logic [BANKS-1:0] slot_err;
  logic             refresh_err;

  sbt_cmd_decode #(
    .BANKS(BANKS), .BA_W(BA_W), .ADDR_W(ROW_W), .FLAG_BIT(10)
  ) u_dec (
    .chip_n(cmd_chip_n), .row_n(cmd_row_n), .col_n(cmd_col_n), .wr_n(cmd_wr_n),
    .bank_sel(bank_sel), .addr(addr_bus),
    .cmd(cmd), .bank_hit(bank_hit), .flag_bit(flag_bit)
  );

  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    sbt_bank_slot #(
      .ROW_W(ROW_W), .GAP_W(GAP_W), .BL_W(BL_W), .DLY_W(DLY_W)
    ) u_slot (
      .clk(clk), .rst(rst), .cmd(cmd), .hit(bank_hit[gb]), .flag_bit(flag_bit),
      .full_page(cfg_full_page), .row_in(addr_bus),
      .act_gap(cfg_act_gap), .pre_gap(cfg_pre_gap),
      .burst_len(cfg_burst_len), .close_dly(cfg_close_dly),
      .is_open(bank_open[gb]), .row(open_row[gb*ROW_W +: ROW_W]),
      .cmd_err(slot_err[gb])
    );
  end

  assign refresh_err = (cmd == CMD_REFRESH) && (|bank_open);

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= (|slot_err) || refresh_err;
  end

  // R5: column access to a closed bank is flagged
  a_r5_rw_closed_bank: assert property (@(posedge clk) disable iff (rst)
    (((cmd == CMD_READ) || (cmd == CMD_WRITE)) && !bank_open[bank_sel]) |=> err_pulse);

  // R4: reopening an open bank is flagged
  a_r4_reopen: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_OPEN) && bank_open[bank_sel]) |=> err_pulse);

  // R11: refresh with a busy bank is flagged
  a_r11_refresh_busy: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_REFRESH) && (|bank_open)) |=> err_pulse);

  // R2: no decoded command means no error next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> !err_pulse);

endmodule

// File: tb/sdram_row_tracker_tb.sv
`timescale 1ns/1ps
module sdram_row_tracker_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        chip_n, row_n, col_n, wr_n;
  logic [1:0]  bank_sel;
  logic [11:0] addr_bus;
  logic [3:0]  act_gap, pre_gap, burst_len, close_dly;
  logic        full_page;
  logic [3:0]  bank_open;
  logic [47:0] open_row;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_row_tracker u_dut (
    .clk(clk), .rst(rst),
    .cmd_chip_n(chip_n), .cmd_row_n(row_n), .cmd_col_n(col_n), .cmd_wr_n(wr_n),
    .bank_sel(bank_sel), .addr_bus(addr_bus),
    .cfg_act_gap(act_gap), .cfg_pre_gap(pre_gap),
    .cfg_burst_len(burst_len), .cfg_close_dly(close_dly), .cfg_full_page(full_page),
    .bank_open(bank_open), .open_row(open_row), .err_pulse(err_pulse)
  );

  // bench codes: 0 none, 1 open, 2 read, 3 write, 4 close, 5 refresh
  // vector: {code[3], bank[2], addr[12], exp_open[4], exp_err[1]}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {3'd5, 2'd0, 12'h000, 4'b0000, 1'b0},  // R11 refresh, all idle
    {3'd2, 2'd0, 12'h000, 4'b0000, 1'b1},  // R5 read closed bank
    {3'd1, 2'd0, 12'h123, 4'b0001, 1'b0},  // R3 open b0 (R12 pulse gone)
    {3'd2, 2'd0, 12'h010, 4'b0001, 1'b1},  // R6 one cycle early
    {3'd2, 2'd0, 12'h010, 4'b0001, 1'b0},  // R6 exactly on gap
    {3'd1, 2'd0, 12'h456, 4'b0001, 1'b1},  // R4 reopen
    {3'd1, 2'd2, 12'hABC, 4'b0101, 1'b0},  // R3 open b2
    {3'd5, 2'd0, 12'h000, 4'b0101, 1'b1},  // R11 refresh busy
    {3'd4, 2'd0, 12'h000, 4'b0100, 1'b0},  // R7 close b0 only
    {3'd1, 2'd0, 12'h0F0, 4'b0100, 1'b1},  // R8 early reopen
    {3'd0, 2'd0, 12'h000, 4'b0100, 1'b0},  // idle
    {3'd1, 2'd0, 12'h0F0, 4'b0101, 1'b0},  // R8 exactly on gap
    {3'd4, 2'd1, 12'h400, 4'b0000, 1'b0},  // R7 close all
    {3'd3, 2'd1, 12'h000, 4'b0000, 1'b1}   // R5 write closed bank
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_raw(input logic c, input logic r, input logic k, input logic w,
                           input logic [1:0] b, input logic [11:0] a);
    chip_n = c; row_n = r; col_n = k; wr_n = w; bank_sel = b; addr_bus = a;
    @(posedge clk);
    @(negedge clk);
    chip_n = 1'b1; row_n = 1'b1; col_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic issue(input logic [2:0] code, input logic [1:0] b, input logic [11:0] a);
    case (code)
      3'd1:    drive_raw(1'b0, 1'b0, 1'b1, 1'b1, b, a);
      3'd2:    drive_raw(1'b0, 1'b1, 1'b0, 1'b1, b, a);
      3'd3:    drive_raw(1'b0, 1'b1, 1'b0, 1'b0, b, a);
      3'd4:    drive_raw(1'b0, 1'b0, 1'b1, 1'b0, b, a);
      3'd5:    drive_raw(1'b0, 1'b0, 1'b0, 1'b1, b, a);
      default: drive_raw(1'b0, 1'b1, 1'b1, 1'b1, b, a);
    endcase
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chip_n = 1'b1; row_n = 1'b1; col_n = 1'b1; wr_n = 1'b1;
    bank_sel = '0; addr_bus = '0;
    act_gap = 4'd2; pre_gap = 4'd3; burst_len = 4'd4; close_dly = 4'd2;
    full_page = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    do_reset();
    check("R1 open after reset", 64'(bank_open), 64'h0);
    check("R1 err after reset", 64'(err_pulse), 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][21:19], VEC[i][18:17], VEC[i][16:5]);
      check($sformatf("vec%0d open", i), 64'(bank_open), 64'(VEC[i][4:1]));
      check($sformatf("vec%0d err", i), 64'(err_pulse), 64'(VEC[i][0]));
      if (i == 6) begin
        check("R4 b0 row unchanged", 64'(open_row[11:0]), 64'h123);
        check("R3 b2 row stored", 64'(open_row[35:24]), 64'hABC);
      end
    end

    // R2: deselected strobes and an unsupported pattern do nothing
    drive_raw(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 12'h111);
    check("R2 deselected open", 64'(bank_open), 64'h0);
    drive_raw(1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 12'h111);
    check("R2 unsupported pattern open", 64'(bank_open), 64'h0);
    check("R2 unsupported pattern err", 64'(err_pulse), 64'h0);

    // R9: self-close after burst_len + close_dly = 6 cycles
    issue(3'd1, 2'd3, 12'h3C3);
    issue(3'd0, 2'd0, 12'h000);
    issue(3'd3, 2'd3, 12'h400);
    check("R9 write accepted", 64'(err_pulse), 64'h0);
    for (int k = 1; k <= 6; k++) begin
      if (k == 1) begin
        issue(3'd2, 2'd3, 12'h000);
        check("R9 access while closing err", 64'(err_pulse), 64'h1);
      end else begin
        issue(3'd0, 2'd0, 12'h000);
      end
      check($sformatf("R9 open at +%0d", k), 64'(bank_open[3]), 64'(k < 6));
    end

    // R10: full-page ignores the self-close flag
    full_page = 1'b1;
    issue(3'd1, 2'd1, 12'h055);
    issue(3'd0, 2'd0, 12'h000);
    issue(3'd2, 2'd1, 12'h400);
    check("R10 read accepted", 64'(err_pulse), 64'h0);
    for (int k = 0; k < 8; k++) issue(3'd0, 2'd0, 12'h000);
    check("R10 bank still open", 64'(bank_open[1]), 64'h1);
    check("R10 row kept", 64'(open_row[23:12]), 64'h055);
    full_page = 1'b0;

    // R1: reset with a bank open
    issue(3'd5, 2'd0, 12'h000);
    do_reset();
    check("R1 mid-run reset open", 64'(bank_open), 64'h0);
    check("R1 mid-run reset err", 64'(err_pulse), 64'h0);
    issue(3'd1, 2'd1, 12'h777);
    check("R1 open right after reset", 64'(bank_open), 64'h2);
    check("R1 open err", 64'(err_pulse), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule